// File: doc/BRIEF.md
# Interval Timer

This block is a 16-bit down-counting timer that raises a level interrupt each time it expires. Software controls it through a small synchronous register port with three 16-bit registers: control/status, modulus and current count. The count steps once per prescaled tick. One tick period is the system clock divided by two, then divided again by a power of two chosen by a 4-bit prescale field.

Expiry is a tick that arrives while the count is zero. On expiry the counter reloads, and a sticky flag is set. In reload mode the counter reloads with the modulus. In free-running mode it reloads with 0xFFFF. The interrupt output is the AND of the flag and its enable.

The flag is cleared by writing a one to it, or by any write to the modulus. An overwrite control bit makes a modulus write load the counter at once. A control write that touches only the interrupt enable or the flag leaves the tick phase alone. Any other control change restarts the prescaler.

Top module: `tick_timer`

## Requirements
- R1: After reset, control and modulus read 0, count reads 0xFFFF, and `irq` is low.
- R2: Offset 0 is control/status, offset 2 is modulus and offset 4 is count. Read data appears one cycle after the address. Control bits are: 0 enable, 1 reload, 2 flag, 3 interrupt enable, 4 overwrite, 5 debug (stored only), 6 doze (stored only), 11:8 prescale. Every other bit reads 0.
- R3: A write to the count offset changes nothing.
- R4: While enabled, a tick occurs every 2^(prescale+1) clock cycles, measured from the control write that last restarted the prescaler. Expiry is a tick with the count at 0.
- R5: With reload set, expiry loads the modulus into the counter.
- R6: With reload clear, expiry loads 0xFFFF into the counter.
- R7: Expiry sets the flag. Writing 1 to bit 2 clears the flag, and that 1 is not stored. Writing 0 to bit 2 keeps the flag. If a clear and an expiry fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while the flag and the interrupt enable are both 1.
- R9: Any modulus write clears the flag, unless an expiry falls in the same cycle.
- R10: A modulus write loads the counter with the written value at once only when overwrite is 1. With overwrite 0 the counter is not touched.
- R11: A control write that differs from the stored value only in interrupt enable or flag does not restart the prescaler. Any other change restarts it. The count holds its value while enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset (0, 2, 4) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the address |
| irq | output | 1 | Level interrupt |

## Verification
The bench times expiries to the exact cycle in reload mode, free-running mode and with a prescale above one. A wrong divider or an off-by-one reload would move the interrupt edge by whole ticks. It lands a flag-clear write on an expiry edge: a design that lets the clear win would drop an interrupt. It also clears the flag on a cycle with no expiry to prove the clear itself works.

Further cases:
- A flag-clear write made mid-period, followed by timing of the next expiry. A design that restarted the prescaler on that write would shift the period.
- Modulus writes with overwrite set and clear. A design that ignored the overwrite bit would corrupt the count or leave it stale.
- Writes of 0 to the flag bit. A plain read-write flag would lose a pending interrupt.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Register byte offsets
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MOD  = 2;
  localparam int unsigned OFS_CNT  = 4;

  // Control/status bit positions (software visible layout)
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_RLD     = 1;
  localparam int unsigned B_FLAG    = 2;
  localparam int unsigned B_IE      = 3;
  localparam int unsigned B_OVW     = 4;
  localparam int unsigned B_DBG     = 5;
  localparam int unsigned B_DOZE    = 6;
  localparam int unsigned B_PRE_LSB = 8;

  // Stored single-bit controls (flag is kept apart: it has its own set/clear rules)
  typedef struct packed {
    logic doze;
    logic dbg;
    logic ovw;
    logic ie;
    logic rld;
    logic en;
  } ctl_bits_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PCNT_W = 1 << PRE_W;
  localparam logic [PCNT_W-1:0] P_ONE = {{(PCNT_W-1){1'b0}}, 1'b1};

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] lim;

  // terminal value = 2^(pre+1) - 1 ; the leading /2 is folded into the +1
  always_comb begin
    lim = ~({PCNT_W{1'b1}} << (32'(pre) + 32'd1));
  end

  assign tick = run && !restart && (pcnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pcnt_q <= '0;
    end else if (pcnt_q == lim) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + P_ONE;
    end
  end

endmodule

// File: rtl/tt_downcount.sv
module tt_downcount #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] limit,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  localparam logic [DATA_W-1:0] C_ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == '0);
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      if (cnt_q == '0) cnt_q <= limit;
      else             cnt_q <= cnt_q - C_ONE;
    end
  end

endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              expire,
  input  logic [DATA_W-1:0] cnt,
  output ctl_bits_t         ctl,
  output logic [PRE_W-1:0]  pre,
  output logic [DATA_W-1:0] mod,
  output logic              flag,
  output logic              restart,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(OFS_MOD);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  ctl_bits_t         ctl_q, ctl_w;
  logic [PRE_W-1:0]  pre_q, pre_w;
  logic [DATA_W-1:0] mod_q;
  logic              flag_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_ctrl, wr_mod;
  logic              flag_clr;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_mod  = bus_we && (bus_addr == A_MOD);

  always_comb begin
    ctl_w.en   = bus_wdata[B_EN];
    ctl_w.rld  = bus_wdata[B_RLD];
    ctl_w.ie   = bus_wdata[B_IE];
    ctl_w.ovw  = bus_wdata[B_OVW];
    ctl_w.dbg  = bus_wdata[B_DBG];
    ctl_w.doze = bus_wdata[B_DOZE];
    pre_w      = bus_wdata[B_PRE_LSB +: PRE_W];
  end

  // anything beyond interrupt enable / flag reconfigures the tick path
  assign restart = wr_ctrl && ((ctl_w.en   != ctl_q.en)  ||
                               (ctl_w.rld  != ctl_q.rld) ||
                               (ctl_w.ovw  != ctl_q.ovw) ||
                               (ctl_w.dbg  != ctl_q.dbg) ||
                               (ctl_w.doze != ctl_q.doze)||
                               (pre_w      != pre_q));

  assign flag_clr = (wr_ctrl && bus_wdata[B_FLAG]) || wr_mod;
  assign load     = wr_mod && ctl_q.ovw;
  assign load_val = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      pre_q  <= '0;
      mod_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctl_q <= ctl_w;
        pre_q <= pre_w;
      end
      if (wr_mod) mod_q <= bus_wdata;
      // expiry has priority over any clear
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      case (bus_addr)
        A_CTRL: begin
          rdata_q[B_EN]   <= ctl_q.en;
          rdata_q[B_RLD]  <= ctl_q.rld;
          rdata_q[B_FLAG] <= flag_q;
          rdata_q[B_IE]   <= ctl_q.ie;
          rdata_q[B_OVW]  <= ctl_q.ovw;
          rdata_q[B_DBG]  <= ctl_q.dbg;
          rdata_q[B_DOZE] <= ctl_q.doze;
          rdata_q[B_PRE_LSB +: PRE_W] <= pre_q;
        end
        A_MOD:   rdata_q <= mod_q;
        A_CNT:   rdata_q <= cnt;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign ctl       = ctl_q;
  assign pre       = pre_q;
  assign mod       = mod_q;
  assign flag      = flag_q;
  assign irq       = flag_q && ctl_q.ie;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctl_bits_t         ctl;
  logic [PRE_W-1:0]  pre;
  logic [DATA_W-1:0] mod_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] limit;
  logic [DATA_W-1:0] load_val;
  logic              flag_q, restart, load, tick, expire;
  logic              run_en, run_rld, run_ovw;

  assign run_en  = ctl.en;
  assign run_rld = ctl.rld;
  assign run_ovw = ctl.ovw;
  assign limit   = run_rld ? mod_q : '1;

  tt_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire(expire), .cnt(cnt_q),
    .ctl(ctl), .pre(pre), .mod(mod_q), .flag(flag_q),
    .restart(restart), .load(load), .load_val(load_val), .irq(irq)
  );

  tt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(run_en), .restart(restart), .pre(pre), .tick(tick)
  );

  tt_downcount #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val),
    .limit(limit), .cnt(cnt_q), .expire(expire)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              tick,
  input logic              expire,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] mod,
  input logic              en,
  input logic              rld,
  input logic              flag
);
  logic modwr;
  assign modwr = bus_we && (bus_addr == ADDR_W'(OFS_MOD));

  assert_reset_R1: assert property (@(posedge clk) rst |=> (cnt == '1 && !irq && !flag));

  assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (expire && rld && !modwr) |=> (cnt == $past(mod)));

  assert_freerun_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && !rld && !modwr) |=> (cnt == '1));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst) expire |=> flag);

  assert_mod_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (modwr && !expire) |=> !flag);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!en && !modwr) |=> $stable(cnt));

endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .irq(irq),
  .tick(tick), .expire(expire), .cnt(cnt_q), .mod(mod_q),
  .en(run_en), .rld(run_rld), .flag(flag_q)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int t0, output int delta);
    int n = 0;
    while (!irq && n < 200000) begin
      @(negedge clk);
      n++;
    end
    delta = cyc - t0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 irq after reset", int'(irq), 0);
    rd(3'd0, v); check("R1 control reset", int'(v), 16'h0000);
    rd(3'd2, v); check("R1 modulus reset", int'(v), 16'h0000);
    rd(3'd4, v); check("R1 count reset", int'(v), 16'hFFFF);
  endtask

  task automatic t_count_ignored;
    logic [15:0] v;
    wr(3'd4, 16'h1234);
    rd(3'd4, v); check("R3 count write ignored", int'(v), 16'hFFFF);
  endtask

  task automatic t_ctrl_layout;
    logic [15:0] v;
    wr(3'd0, 16'h0F7A);
    rd(3'd0, v); check("R2 control readback", int'(v), 16'h0F7A);
    wr(3'd0, 16'h0F7E);
    rd(3'd0, v); check("R7 written flag one not stored", int'(v), 16'h0F7A);
    wr(3'd0, 16'hF0FA);
    rd(3'd0, v); check("R2 undefined bits read zero", int'(v), 16'h007A);
  endtask

  task automatic t_overwrite;
    logic [15:0] v;
    wr(3'd0, 16'h0010);
    wr(3'd2, 16'h0005);
    rd(3'd4, v); check("R10 overwrite loads count", int'(v), 16'h0005);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0009);
    rd(3'd4, v); check("R10 no overwrite keeps count", int'(v), 16'h0005);
    rd(3'd2, v); check("R2 modulus readback", int'(v), 16'h0009);
  endtask

  task automatic t_reload;
    int t0, d;
    wr(3'd0, 16'h0012);
    wr(3'd2, 16'h0004);
    wr(3'd0, 16'h001B);
    t0 = cyc;
    wait_irq(t0, d); check("R5 first reload expiry cycle", d, 10);
    wr(3'd0, 16'h001F);
    check("R7 flag cleared by writing one", int'(irq), 0);
    wait_irq(t0, d); check("R11 period kept across flag-only write", d, 20);
    check("R8 irq with flag and enable", int'(irq), 1);
  endtask

  task automatic t_prescale;
    int t0, d;
    wr(3'd0, 16'h0012);
    wr(3'd2, 16'h0001);
    check("R9 modulus write clears flag", int'(irq), 0);
    wr(3'd0, 16'h021B);
    t0 = cyc;
    wait_irq(t0, d); check("R4 prescale 2 expiry cycle", d, 16);
  endtask

  task automatic t_freerun;
    int t0, d;
    logic [15:0] v;
    wr(3'd0, 16'h0010);
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h0019);
    t0 = cyc;
    wait_irq(t0, d); check("R4 free-run expiry cycle", d, 6);
    rd(3'd4, v); check("R6 free-run reload value", int'(v), 16'hFFFF);
    wr(3'd0, 16'h0011);
    check("R8 irq low with enable off", int'(irq), 0);
    rd(3'd0, v); check("R7 flag kept by writing zero", int'(v), 16'h0015);
    wr(3'd0, 16'h0018);
    check("R8 irq returns with enable on", int'(irq), 1);
    wr(3'd2, 16'h0007);
    check("R9 modulus write clears irq", int'(irq), 0);
    rd(3'd4, v); check("R10 overwrite load while disabled", int'(v), 16'h0007);
    wr(3'd0, 16'h0008);
    wr(3'd2, 16'h0003);
    repeat (20) @(negedge clk);
    rd(3'd4, v); check("R11 count holds while disabled", int'(v), 16'h0007);
  endtask

  task automatic t_set_wins;
    wr(3'd0, 16'h0012);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h001B);
    @(negedge clk);
    @(negedge clk);
    check("R4 expiry every tick at modulus zero", int'(irq), 1);
    wr(3'd0, 16'h001F);
    check("R7 clear off expiry edge", int'(irq), 0);
    wr(3'd0, 16'h001F);
    check("R7 expiry beats clear", int'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count_ignored();
    t_ctrl_layout();
    t_overwrite();
    t_reload();
    t_prescale();
    t_freerun();
    t_set_wins();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      report();
      $finish;
    end
  end

endmodule